// File: doc/BRIEF.md
# Predicated SIMD Core Grid

This block is a rectangular array of identical 32-bit processing cores. All of them execute one shared instruction stream in lock step. Each core owns a small register file. Every core addresses that file with the same index, so a variable sits at the same address in every core. A core knows its fixed row and column. It can read the register at the current index in its east or west neighbour: even columns look east and odd columns look west. Any missing neighbour at the grid edge reads as zero.

A 64-bit broadcast word carries constants to every core in the same cycle. Even-column cores use bits 31:0 and odd-column cores use bits 63:32. An instruction with the advance flag set latches a fresh word from the broadcast input and uses it at once. The block also raises a strobe so that the upstream source moves to its next word. Without the flag, the last latched word is reused.

Each core decides whether to write back from a per-instruction predicate mode. The predicate is evaluated on that core's own runtime data: its column parity, or whether its target register is non-zero. A false predicate suppresses write-back in that core only.

Top module: `simd_grid`

## Requirements
- R1: While `rst` is high at a clock edge, every register-file entry of every core and the held broadcast word are cleared to zero.
- R2: Opcode 2 (load lane) writes the core's broadcast lane into entry `in_idx`: bits 31:0 of the effective word for even columns, bits 63:32 for odd columns.
- R3: Opcode 3 (load id) writes `row*COLS + col` plus the core's broadcast lane into entry `in_idx`.
- R4: Opcode 1 (accumulate) writes `rf[idx] + nbr*in_k + lane` into entry `in_idx`, with all arithmetic wrapping modulo 2^32.
- R5: In an accumulate, `nbr` is the neighbour's entry `in_idx` as it stood before the instruction. Even columns read the east neighbour (col+1) and odd columns read the west neighbour (col-1).
- R6: A core whose selected neighbour lies outside the grid uses zero as `nbr`.
- R7: Predicate mode 0 writes in all cores, mode 1 only in even columns, and mode 2 only in odd columns. Mode 3 writes only where the core's current entry `in_idx` is non-zero. A core whose predicate is false keeps all its entries.
- R8: When `in_valid` and `in_pop` are both high, the instruction uses `bc_data` as its broadcast word, that word is held for later instructions, and `bc_pop` is high in that cycle. Otherwise the held word is used and `bc_pop` is low.
- R9: With `in_valid` low, or with opcode 0, no register-file entry changes. With `in_valid` low, the held broadcast word also does not change.
- R10: An instruction changes only entry `in_idx` in each core, and all cores use the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Shared instruction is present this cycle |
| in_op | input | 2 | Opcode: 0 none, 1 accumulate, 2 load lane, 3 load id |
| in_pmode | input | 2 | Predicate mode: 0 all, 1 even columns, 2 odd columns, 3 target non-zero |
| in_idx | input | IDXW | Register-file index used by every core |
| in_k | input | 32 | Multiplier for the neighbour operand |
| in_pop | input | 1 | Latch and use `bc_data` as the new broadcast word |
| bc_data | input | 64 | Broadcast word offered by the source |
| bc_pop | output | 1 | Strobe asking the source for its next word |
| rd_idx | input | IDXW | Read-out index, same in every core |
| rd_data | output | ROWS*COLS*32 | Entry `rd_idx` of every core, core (r,c) at slice r*COLS+c |

## Verification
The case of most interest is an accumulate that also advances the broadcast word. In that cycle every core overwrites the entry its neighbours are reading. The fresh word must be used and latched, while each neighbour operand is still the value from before the edge. The bench issues such an instruction after loading distinct per-core ids into the target entry. It then compares every core against a model that reads the old neighbour values and the new lanes. A later instruction without the advance flag shows that the popped word was held.

// File: rtl/simd_grid_pkg.sv
package simd_grid_pkg;

    localparam int DW  = 32;
    localparam int BCW = 2 * DW;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ACC   = 2'd1,
        OP_LANE  = 2'd2,
        OP_ID    = 2'd3
    } grid_op_e;

    typedef enum logic [1:0] {
        PM_ALL   = 2'd0,
        PM_EVEN  = 2'd1,
        PM_ODD   = 2'd2,
        PM_NZ    = 2'd3
    } pred_mode_e;

    typedef struct packed {
        grid_op_e          op;
        pred_mode_e        pmode;
        logic [DW-1:0]     k;
    } grid_instr_t;

    function automatic logic [DW-1:0] lane_pick(input logic [BCW-1:0] w, input logic odd);
        return odd ? w[BCW-1:DW] : w[DW-1:0];
    endfunction

    function automatic logic pred_eval(input pred_mode_e m, input logic odd,
                                       input logic [DW-1:0] cur);
        logic p;
        case (m)
            PM_ALL:  p = 1'b1;
            PM_EVEN: p = !odd;
            PM_ODD:  p = odd;
            default: p = (cur != '0);
        endcase
        return p;
    endfunction

endpackage

// File: rtl/simd_alu.sv
module simd_alu
    import simd_grid_pkg::*;
(
    input  grid_op_e      op,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] nbr,
    input  logic [DW-1:0] k,
    input  logic [DW-1:0] lane,
    input  logic [DW-1:0] pos_id,
    output logic [DW-1:0] result
);
    logic [DW-1:0] prod;

    always_comb begin
        prod = nbr * k;
        case (op)
            OP_ACC:  result = cur + prod + lane;
            OP_LANE: result = lane;
            OP_ID:   result = pos_id + lane;
            default: result = cur;
        endcase
    end
endmodule

// File: rtl/simd_bcast.sv
module simd_bcast
    import simd_grid_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           valid,
    input  logic           pop,
    input  logic [BCW-1:0] src_word,
    output logic [BCW-1:0] eff_word,
    output logic           pop_strobe
);
    logic [BCW-1:0] held_q;
    logic           take;

    assign take       = valid && pop;
    assign eff_word   = take ? src_word : held_q;
    assign pop_strobe = take;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (take)
            held_q <= src_word;
    end

    // R8
    bc_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && pop) |=> (held_q == $past(src_word)));

    // R9
    bc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(held_q));
endmodule

// File: rtl/simd_core.sv
module simd_core
    import simd_grid_pkg::*;
#(
    parameter int ROW   = 0,
    parameter int COL   = 0,
    parameter int COLS  = 4,
    parameter int DEPTH = 8,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  grid_instr_t     ins,
    input  logic [IDXW-1:0] idx,
    input  logic [BCW-1:0]  bc_word,
    input  logic [DW-1:0]   nbr_east,
    input  logic [DW-1:0]   nbr_west,
    output logic [DW-1:0]   share_val,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_val
);
    localparam logic          IS_ODD = (COL % 2) == 1;
    localparam logic [DW-1:0] POS_ID = DW'(ROW * COLS + COL);

    logic [DEPTH-1:0][DW-1:0] rf_q;
    logic [DW-1:0] cur, nbr, lane, res;
    logic          pred_ok, we;

    assign cur       = rf_q[idx];
    assign share_val = cur;
    assign rd_val    = rf_q[rd_idx];
    assign nbr       = IS_ODD ? nbr_west : nbr_east;
    assign lane      = lane_pick(bc_word, IS_ODD);
    assign pred_ok   = pred_eval(ins.pmode, IS_ODD, cur);
    assign we        = valid && (ins.op != OP_NONE) && pred_ok;

    simd_alu alu_i (
        .op     (ins.op),
        .cur    (cur),
        .nbr    (nbr),
        .k      (ins.k),
        .lane   (lane),
        .pos_id (POS_ID),
        .result (res)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rf_q <= '0;
        else if (we)
            rf_q[idx] <= res;
    end

    // R1
    rf_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (rf_q == '0));

    // R9
    rf_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid || ins.op == OP_NONE) |=> $stable(rf_q));

    // R7
    parity_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && ((ins.pmode == PM_EVEN && IS_ODD) || (ins.pmode == PM_ODD && !IS_ODD)))
        |=> $stable(rf_q));

    // R7
    nz_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && ins.pmode == PM_NZ && cur == '0) |=> $stable(rf_q));
endmodule

// File: rtl/simd_grid.sv
module simd_grid
    import simd_grid_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int DEPTH = 8,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NCORE = ROWS * COLS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            in_op,
    input  logic [1:0]            in_pmode,
    input  logic [IDXW-1:0]       in_idx,
    input  logic [31:0]           in_k,
    input  logic                  in_pop,
    input  logic [63:0]           bc_data,
    output logic                  bc_pop,
    input  logic [IDXW-1:0]       rd_idx,
    output logic [NCORE*32-1:0]   rd_data
);
    grid_instr_t    ins;
    logic [BCW-1:0] eff_word;
    logic [DW-1:0]  share [ROWS][COLS];

    assign ins.op    = grid_op_e'(in_op);
    assign ins.pmode = pred_mode_e'(in_pmode);
    assign ins.k     = in_k;

    simd_bcast bcast_i (
        .clk        (clk),
        .rst        (rst),
        .valid      (in_valid),
        .pop        (in_pop),
        .src_word   (bc_data),
        .eff_word   (eff_word),
        .pop_strobe (bc_pop)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [DW-1:0] east_v, west_v;

            if (c + 1 < COLS) begin : g_east
                assign east_v = share[r][c+1];
            end else begin : g_east_edge
                assign east_v = '0;
            end

            if (c > 0) begin : g_west
                assign west_v = share[r][c-1];
            end else begin : g_west_edge
                assign west_v = '0;
            end

            simd_core #(
                .ROW   (r),
                .COL   (c),
                .COLS  (COLS),
                .DEPTH (DEPTH)
            ) core_i (
                .clk       (clk),
                .rst       (rst),
                .valid     (in_valid),
                .ins       (ins),
                .idx       (in_idx),
                .bc_word   (eff_word),
                .nbr_east  (east_v),
                .nbr_west  (west_v),
                .share_val (share[r][c]),
                .rd_idx    (rd_idx),
                .rd_val    (rd_data[(r*COLS+c)*DW +: DW])
            );
        end
    end
endmodule

// File: tb/simd_grid_tb_top.sv
module simd_grid_tb_top;
    localparam int R = 3;
    localparam int C = 5;
    localparam int D = 8;
    localparam int IW = $clog2(D);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [1:0]      in_op = 2'd0;
    logic [1:0]      in_pmode = 2'd0;
    logic [IW-1:0]   in_idx = '0;
    logic [31:0]     in_k = '0;
    logic            in_pop = 1'b0;
    logic [63:0]     bc_data = '0;
    logic            bc_pop;
    logic [IW-1:0]   rd_idx = '0;
    logic [R*C*32-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m [R][C][D];
    logic [63:0] hold = '0;

    always #5 clk = ~clk;

    simd_grid #(.ROWS(R), .COLS(C), .DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_pmode(in_pmode), .in_idx(in_idx), .in_k(in_k), .in_pop(in_pop),
        .bc_data(bc_data), .bc_pop(bc_pop), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_idx(input int idx, input string req);
        rd_idx = IW'(idx);
        #1;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                chk(req, 64'(rd_data[(r*C+c)*32 +: 32]), 64'(m[r][c][idx]));
    endtask

    // Drives one instruction at a falling edge and updates the model at the rising edge.
    task automatic issue(input int op, input int pm, input int idx, input logic [31:0] k,
                         input logic pop, input logic [63:0] bc, input string req);
        logic [31:0] nx [R][C];
        logic [63:0] eff;
        eff = pop ? bc : hold;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                logic odd, p;
                logic [31:0] lane, cur, nbr;
                odd  = (c % 2) == 1;
                lane = odd ? eff[63:32] : eff[31:0];
                cur  = m[r][c][idx];
                if (odd) nbr = (c > 0) ? m[r][c-1][idx] : 32'd0;
                else     nbr = (c < C-1) ? m[r][c+1][idx] : 32'd0;
                case (pm)
                    0: p = 1'b1;
                    1: p = !odd;
                    2: p = odd;
                    default: p = (cur != 0);
                endcase
                nx[r][c] = cur;
                if (p) begin
                    case (op)
                        1: nx[r][c] = cur + nbr * k + lane;
                        2: nx[r][c] = lane;
                        3: nx[r][c] = 32'(r*C + c) + lane;
                        default: nx[r][c] = cur;
                    endcase
                end
            end
        in_valid = 1'b1; in_op = 2'(op); in_pmode = 2'(pm); in_idx = IW'(idx);
        in_k = k; in_pop = pop; bc_data = bc;
        #1;
        chk({req, " R8 strobe"}, 64'(bc_pop), 64'(pop));
        @(posedge clk);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                m[r][c][idx] = nx[r][c];
        if (pop) hold = bc;
        @(negedge clk);
        in_valid = 1'b0; in_pop = 1'b0; bc_data = 64'hDEAD_BEEF_0BAD_F00D;
    endtask

    task automatic t_reset();
        for (int i = 0; i < D; i++) check_idx(i, "R1 reset");
        chk("R1 strobe idle", 64'(bc_pop), 64'd0);
    endtask

    task automatic t_lane();
        issue(2, 0, 1, 0, 1'b1, {32'hBBBB_0002, 32'hAAAA_0001}, "R2");
        check_idx(1, "R2 lane by parity");
        check_idx(0, "R10 other entry");
    endtask

    task automatic t_id();
        issue(3, 0, 2, 0, 1'b1, {32'h0000_0100, 32'h0000_0000}, "R3");
        check_idx(2, "R3 id plus lane");
    endtask

    task automatic t_acc_pop();
        issue(3, 0, 3, 0, 1'b1, 64'd0, "R5 prep");
        issue(1, 0, 3, 32'd3, 1'b1, {32'd100, 32'd10}, "R5");
        check_idx(3, "R5 R6 neighbour and edge");
        issue(1, 0, 3, 32'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        check_idx(3, "R8 held word reused");
    endtask

    task automatic t_wrap();
        issue(2, 0, 7, 0, 1'b1, 64'hFFFF_FFF0_FFFF_FFFF, "R4 prep");
        issue(1, 0, 7, 32'h8000_0003, 1'b1, {32'hFFFF_FFFF, 32'h7FFF_FFFF}, "R4");
        check_idx(7, "R4 wraparound");
    endtask

    task automatic t_pred();
        issue(2, 1, 4, 0, 1'b1, {32'd2, 32'd1}, "R7 even");
        check_idx(4, "R7 even only");
        issue(2, 2, 4, 0, 1'b1, {32'd4, 32'd3}, "R7 odd");
        check_idx(4, "R7 odd only");
        issue(1, 3, 4, 32'd2, 1'b1, {32'd6, 32'd5}, "R7 nz");
        check_idx(4, "R7 nonzero all");
        issue(2, 3, 5, 0, 1'b1, {32'd9, 32'd9}, "R7 nz zero");
        check_idx(5, "R7 nonzero none");
    endtask

    task automatic t_idle();
        in_valid = 1'b0; in_op = 2'd2; in_pmode = 2'd0; in_idx = IW'(6);
        in_pop = 1'b1; bc_data = 64'h1234_5678_9ABC_DEF0;
        #1;
        chk("R9 no strobe when idle", 64'(bc_pop), 64'd0);
        @(posedge clk);
        @(negedge clk);
        in_pop = 1'b0;
        check_idx(6, "R9 idle no write");
        issue(0, 0, 6, 32'd5, 1'b0, 64'd0, "R9 none");
        check_idx(6, "R9 none opcode");
        issue(2, 0, 6, 0, 1'b0, 64'h5555_5555_5555_5555, "R9");
        check_idx(6, "R9 held word survived idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                for (int i = 0; i < D; i++) m[r][c][i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lane();
        t_id();
        t_acc_pop();
        t_wrap();
        t_pred();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule